// File: doc/BRIEF.md
# Byte Multiplier with Signed, Mixed and Fractional Modes

This unit multiplies two 8-bit register operands and returns a 16-bit product bound for the fixed register pair r1:r0. The high byte goes to r1 and the low byte goes to r0. A 3-bit mode selects one of six forms. The three integer forms are unsigned by unsigned, signed by signed, and signed by unsigned. Each fractional form computes the same product as its integer partner and then shifts it left by one bit. The unit also produces the zero (Z) and carry (C) status bits.

The decoder presents the operand values together with their register indices. The unit checks the indices against the register window that the selected mode allows. An operand outside that window raises an illegal-operand pulse, and the write is suppressed. A one-cycle `start` pulse launches an operation. `done` pulses exactly two clock edges later, and a new operation may start on every cycle. Register file storage and instruction decode belong to neighbouring blocks.

Top module: `mul_unit`

## Requirements
- R1: Mode 0 (unsigned by unsigned) returns the 16-bit product of both operands read as unsigned.
- R2: Mode 1 (signed by signed) returns the two's complement product of both operands read as signed.
- R3: Mode 2 (signed by unsigned) reads the destination-field operand `op_d` as signed and the source-field operand `op_r` as unsigned.
- R4: Modes 3, 4 and 5 are the fractional forms of modes 0, 1 and 2. Each returns its partner's 16-bit product shifted left by one, with bit 0 equal to zero.
- R5: On a legal operation, `flag_z` is 1 exactly when the final 16-bit result is zero.
- R6: On a legal operation, `flag_c` equals bit 15 of the product before any fractional shift.
- R7: `done` pulses high in the second cycle after a `start` pulse. `wr_en` pulses in that same cycle when the operation is legal. `done` and `wr_en` are never high at any other time.
- R8: Register windows are as follows. Mode 0 accepts indices 0 to 31 for both operands. Mode 1 accepts 16 to 31 for both operands. Modes 2 to 5 accept 16 to 23 for both operands. An index outside the window makes `illegal` pulse with `done`, keeps `wr_en` low, and leaves `prod`, `flag_z` and `flag_c` unchanged.
- R9: Mode codes 6 and 7 are illegal for every operand index.
- R10: After reset, `done`, `wr_en` and `illegal` are 0, and `prod`, `flag_z` and `flag_c` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle launch of an operation |
| mode | input | 3 | Multiply form, codes 0 to 5 (6 and 7 illegal) |
| op_d | input | 8 | Destination-field operand value |
| op_r | input | 8 | Source-field operand value |
| idx_d | input | 5 | Register index of `op_d` |
| idx_r | input | 5 | Register index of `op_r` |
| done | output | 1 | Operation complete, one-cycle pulse |
| wr_en | output | 1 | Write strobe for r1:r0 |
| illegal | output | 1 | Operand index out of window, pulses with `done` |
| prod | output | 16 | Result; bits 15:8 go to r1 and bits 7:0 go to r0 |
| flag_z | output | 1 | Zero status bit |
| flag_c | output | 1 | Carry status bit |

## Verification
The bench drives `start` with operands on a falling edge. It checks that `done` is still low one falling edge later. On the second falling edge it expects `done`, `wr_en`, `illegal`, `prod` and both flags all at once, since every result comes out of the same second register stage. Illegal operations compare `prod` and the flags against the values the bench kept from the last legal operation. This confirms the hold behaviour at the ports before the next launch. Back-to-back launches check that one operation in flight does not disturb the timing of the next.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int DW = 8;
  localparam int IW = 5;
  localparam int PW = 2 * DW;

  typedef enum logic [2:0] {
    MD_UU  = 3'd0,
    MD_SS  = 3'd1,
    MD_SU  = 3'd2,
    MD_FUU = 3'd3,
    MD_FSS = 3'd4,
    MD_FSU = 3'd5,
    MD_BAD6 = 3'd6,
    MD_BAD7 = 3'd7
  } mul_mode_e;

  // register window class required by a mode
  typedef enum logic [1:0] {
    WIN_ALL,
    WIN_UPPER,
    WIN_NARROW,
    WIN_NONE
  } win_e;

  function automatic win_e mode_window(input mul_mode_e m);
    case (m)
      MD_UU:                          return WIN_ALL;
      MD_SS:                          return WIN_UPPER;
      MD_SU, MD_FUU, MD_FSS, MD_FSU:  return WIN_NARROW;
      default:                        return WIN_NONE;
    endcase
  endfunction

  function automatic logic mode_is_frac(input mul_mode_e m);
    return (m == MD_FUU) || (m == MD_FSS) || (m == MD_FSU);
  endfunction

  // destination-field operand signed?
  function automatic logic d_signed(input mul_mode_e m);
    return (m == MD_SS) || (m == MD_SU) || (m == MD_FSS) || (m == MD_FSU);
  endfunction

  // source-field operand signed?
  function automatic logic r_signed(input mul_mode_e m);
    return (m == MD_SS) || (m == MD_FSS);
  endfunction
endpackage

// File: rtl/mul_range_check.sv
module mul_range_check
  import mul_pkg::*;
#(
  parameter int IDXW = IW
) (
  input  mul_mode_e        mode,
  input  logic [IDXW-1:0]  idx_a,
  input  logic [IDXW-1:0]  idx_b,
  output logic             legal
);
  localparam int NREG   = 1 << IDXW;
  localparam int UP_LO  = NREG / 2;
  localparam int NAR_HI = UP_LO + NREG / 4 - 1;

  logic [1:0] in_upper;
  logic [1:0] in_narrow;
  logic [IDXW-1:0] idx_pair [2];

  assign idx_pair[0] = idx_a;
  assign idx_pair[1] = idx_b;

  for (genvar g = 0; g < 2; g++) begin : g_idx
    assign in_upper[g]  = (int'(idx_pair[g]) >= UP_LO);
    assign in_narrow[g] = (int'(idx_pair[g]) >= UP_LO) &&
                          (int'(idx_pair[g]) <= NAR_HI);
  end

  always_comb begin
    case (mode_window(mode))
      WIN_ALL:    legal = 1'b1;
      WIN_UPPER:  legal = &in_upper;
      WIN_NARROW: legal = &in_narrow;
      default:    legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/mul_core.sv
module mul_core
  import mul_pkg::*;
#(
  parameter int W = DW
) (
  input  mul_mode_e      mode,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] raw,
  output logic [2*W-1:0] result
);
  logic signed [W:0]     ext_a;
  logic signed [W:0]     ext_b;
  logic signed [2*W+1:0] full;

  assign ext_a = {d_signed(mode) & a[W-1], a};
  assign ext_b = {r_signed(mode) & b[W-1], b};
  assign full  = ext_a * ext_b;
  assign raw   = full[2*W-1:0];
  assign result = mode_is_frac(mode) ? {raw[2*W-2:0], 1'b0} : raw;
endmodule

// File: rtl/mul_flags.sv
module mul_flags #(
  parameter int PWID = 16
) (
  input  logic [PWID-1:0] raw,
  input  logic [PWID-1:0] result,
  output logic            z,
  output logic            c
);
  assign z = (result == '0);
  assign c = raw[PWID-1];
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [7:0]    op_d,
  input  logic [7:0]    op_r,
  input  logic [4:0]    idx_d,
  input  logic [4:0]    idx_r,
  output logic          done,
  output logic          wr_en,
  output logic          illegal,
  output logic [15:0]   prod,
  output logic          flag_z,
  output logic          flag_c
);
  // stage 1: capture
  logic             s1_vld;
  mul_mode_e        s1_mode;
  logic [DW-1:0]    s1_a;
  logic [DW-1:0]    s1_b;
  logic             s1_legal;

  // named events for checking
  logic             start_evt;
  logic             legal_evt;
  logic             frac_evt;
  logic             frac_q;

  mul_mode_e        in_mode;
  logic             in_legal;
  logic [PW-1:0]    raw_w;
  logic [PW-1:0]    res_w;
  logic             z_w;
  logic             c_w;

  assign in_mode   = mul_mode_e'(mode);
  assign start_evt = start;

  mul_range_check #(.IDXW(IW)) u_range (
    .mode  (in_mode),
    .idx_a (idx_d),
    .idx_b (idx_r),
    .legal (in_legal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_mode  <= MD_UU;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_legal <= 1'b0;
    end else begin
      s1_vld <= start;
      if (start) begin
        s1_mode  <= in_mode;
        s1_a     <= op_d;
        s1_b     <= op_r;
        s1_legal <= in_legal;
      end
    end
  end

  mul_core #(.W(DW)) u_core (
    .mode   (s1_mode),
    .a      (s1_a),
    .b      (s1_b),
    .raw    (raw_w),
    .result (res_w)
  );

  mul_flags #(.PWID(PW)) u_flags (
    .raw    (raw_w),
    .result (res_w),
    .z      (z_w),
    .c      (c_w)
  );

  assign legal_evt = s1_vld & s1_legal;
  assign frac_evt  = legal_evt & mode_is_frac(s1_mode);

  // stage 2: result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      wr_en   <= 1'b0;
      illegal <= 1'b0;
      prod    <= '0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
      frac_q  <= 1'b0;
    end else begin
      done    <= s1_vld;
      wr_en   <= legal_evt;
      illegal <= s1_vld & ~s1_legal;
      frac_q  <= frac_evt;
      if (legal_evt) begin
        prod   <= res_w;
        flag_z <= z_w;
        flag_c <= c_w;
      end
    end
  end
endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic        wr_en,
  input logic        illegal,
  input logic [15:0] prod,
  input logic        flag_z,
  input logic        flag_c,
  input logic        frac_done
);
  a_r7_done_after_two: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 done);
  a_r7_wr_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);
  a_r8_illegal_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !wr_en));
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(prod) && $stable(flag_z) && $stable(flag_c)));
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flag_z == (prod == 16'h0000)));
  a_r4_frac_lsb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && frac_done) |-> (prod[0] == 1'b0));
  a_r7_single_status: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, illegal}));
endmodule

bind mul_unit mul_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .wr_en     (wr_en),
  .illegal   (illegal),
  .prod      (prod),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .frac_done (frac_q)
);

// File: tb/mul_unit_test.sv
module mul_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  op_d = '0;
  logic [7:0]  op_r = '0;
  logic [4:0]  idx_d = '0;
  logic [4:0]  idx_r = '0;
  logic        done, wr_en, illegal, flag_z, flag_c;
  logic [15:0] prod;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [15:0] keep_prod = '0;
  logic        keep_z = 0, keep_c = 0;

  always #2 clk = ~clk;

  mul_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .op_d(op_d), .op_r(op_r), .idx_d(idx_d), .idx_r(idx_r),
    .done(done), .wr_en(wr_en), .illegal(illegal), .prod(prod),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int as_signed(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int bench_raw(input int m, input int a, input int b);
    int p;
    case (m % 3)
      0: p = a * b;
      1: p = as_signed(a) * as_signed(b);
      default: p = as_signed(a) * b;
    endcase
    return p & 16'hFFFF;
  endfunction

  function automatic bit bench_legal(input int m, input int ia, input int ib);
    if (m == 0) return 1;
    if (m == 1) return (ia >= 16) && (ib >= 16);
    if (m <= 5) return (ia >= 16) && (ia <= 23) && (ib >= 16) && (ib <= 23);
    return 0;
  endfunction

  task automatic run_op(input int m, input int a, input int b,
                        input int ia, input int ib, input string tag);
    int raw, fin;
    bit lg;
    raw = bench_raw(m, a, b);
    fin = (m >= 3) ? ((raw << 1) & 16'hFFFF) : raw;
    lg  = bench_legal(m, ia, ib);
    @(negedge clk);
    start = 1; mode = 3'(m); op_d = 8'(a); op_r = 8'(b);
    idx_d = 5'(ia); idx_r = 5'(ib);
    @(negedge clk);
    start = 0;
    check({tag, " R7 early done"}, int'(done), 0);
    @(negedge clk);
    check({tag, " R7 done"}, int'(done), 1);
    check({tag, " R8 wr_en"}, int'(wr_en), int'(lg));
    check({tag, " R8 illegal"}, int'(illegal), int'(!lg));
    if (lg) begin
      keep_prod = 16'(fin);
      keep_z = (fin == 0);
      keep_c = raw[15];
    end
    check({tag, " R1-R4 prod"}, int'(prod), int'(keep_prod));
    check({tag, " R5 flag_z"}, int'(flag_z), int'(keep_z));
    check({tag, " R6 flag_c"}, int'(flag_c), int'(keep_c));
  endtask

  initial begin
    int seed_dummy;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 done", int'(done), 0);
    check("R10 wr_en", int'(wr_en), 0);
    check("R10 illegal", int'(illegal), 0);
    check("R10 prod", int'(prod), 0);
    check("R10 flags", int'({flag_z, flag_c}), 0);
    rst_n = 1;
    // directed corners
    run_op(0, 255, 255, 0, 31, "R1 max");
    run_op(0, 0, 77, 3, 9, "R1 R5 zero");
    run_op(1, 128, 128, 16, 31, "R2 min*min");
    run_op(1, 255, 1, 20, 30, "R2 neg");
    run_op(2, 255, 255, 16, 23, "R3 mixed");
    run_op(2, 1, 255, 17, 18, "R3 rs unsigned");
    run_op(3, 255, 255, 16, 16, "R4 fuu");
    run_op(4, 128, 128, 23, 23, "R4 fss");
    run_op(5, 128, 255, 19, 22, "R4 fsu");
    run_op(4, 64, 0, 16, 17, "R4 R5 zero");
    run_op(1, 3, 4, 15, 16, "R8 ss low idx");
    run_op(2, 3, 4, 24, 16, "R8 su idx24");
    run_op(3, 3, 4, 16, 15, "R8 frac idx15");
    run_op(6, 5, 5, 16, 16, "R9 code6");
    run_op(7, 5, 5, 0, 0, "R9 code7");
    // back-to-back launches (R7)
    @(negedge clk);
    start = 1; mode = 3'd0; op_d = 8'd10; op_r = 8'd20; idx_d = 0; idx_r = 1;
    @(negedge clk);
    op_d = 8'd3; op_r = 8'd7;
    @(negedge clk);
    start = 0;
    check("R7 b2b first done", int'(done), 1);
    check("R1 b2b first prod", int'(prod), 200);
    @(negedge clk);
    check("R7 b2b second done", int'(done), 1);
    check("R1 b2b second prod", int'(prod), 21);
    @(negedge clk);
    check("R7 b2b idle", int'(done), 0);
    keep_prod = 16'd21; keep_z = 0; keep_c = 0;
    // constrained random
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < 400; i++) begin
      int m, ia, ib;
      m = $urandom_range(0, 7);
      if ($urandom_range(0, 3) != 0 && m != 0) begin
        ia = $urandom_range(16, (m == 1) ? 31 : 23);
        ib = $urandom_range(16, (m == 1) ? 31 : 23);
      end else begin
        ia = $urandom_range(0, 31);
        ib = $urandom_range(0, 31);
      end
      run_op(m, $urandom_range(0, 255), $urandom_range(0, 255), ia, ib, "rnd");
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule